// File: doc/BRIEF.md
# Protected Event Interrupt Controller

This block gathers 49 hardware event lines into a single interrupt controller that software reaches through a small word-addressed register port. Each source keeps a sticky pending bit. Its own event sets that bit. Software can also raise the bit by hand or drop it. A per-source mask gates each source onto a maskable interrupt line. A second, separate non-maskable line is fed from the pending bits through its own routing and ignores the mask. The event lines are also passed straight out, before any gating. This lets a system-level interrupt controller take over the sources directly.

The register port carries a privilege flag with each access. Any source can be locked. Once a source is locked, only privileged accesses can raise or drop its pending bit. Only privileged writes can change the lock settings.

Each function occupies two 32-bit words. Sources 0 to 31 sit in the low word and sources 32 to 48 sit in the high word. The word offsets are listed in R11.

Top module: `evt_guard_intc`

## Requirements
- R1: After a synchronous reset, every readable register reads zero and both `irq_out` and `nmi_out` are low.
- R2: An event input that is high at a clock edge sets that source's pending bit at that edge. The bit reads back as 1 from then on until it is cleared.
- R3: A write to the set word (offset 0x10 low, 0x14 high) sets the pending bit of every source whose data bit is 1. Bits written as 0 leave their sources untouched.
- R4: A write to the clear word (offset 0x18 low, 0x1C high) drops the pending bit of every source whose data bit is 1. Bits written as 0 leave their sources untouched.
- R5: `irq_out` is the OR over all sources of pending AND mask (0x00/0x04) AND IRQ routing (0x20/0x24). It is registered, so it follows a pending change one cycle later.
- R6: `nmi_out` is the OR over all sources of pending AND NMI routing (0x28/0x2C). The mask has no effect on it, and it follows a pending change one cycle later.
- R7: `trig_out` equals `evt_in` in the same cycle, with no masking.
- R8: For a source whose lock bit (0x30/0x34) is 1, a set or clear from an unprivileged access (`bus_priv` = 0) has no effect. Unlocked sources named in the same write still take effect.
- R9: A write to the lock words changes them only when `bus_priv` is 1. An unprivileged write leaves the lock words unchanged.
- R10: When an event and a software clear hit the same source in the same cycle, the pending bit stays 1.
- R11: The map uses these offsets:
  - 0x00/0x04: mask
  - 0x08/0x0C: pending, read-only; writes are ignored
  - 0x10/0x14: set, reads 0
  - 0x18/0x1C: clear, reads 0
  - 0x20/0x24: IRQ routing
  - 0x28/0x2C: NMI routing
  - 0x30/0x34: lock

  High-word bits 17 to 31 read 0 and ignore writes. Offsets 0x38 to 0x5C read 0. Accesses whose two low address bits are not zero are ignored and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 49 | Hardware event lines, one per source |
| bus_sel | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = privileged access |
| bus_addr | input | 7 | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| irq_out | output | 1 | Registered maskable interrupt |
| nmi_out | output | 1 | Registered non-maskable interrupt |
| trig_out | output | 49 | Unmasked copy of the event lines |

## Verification
Two functions can touch the same pending bit in one clock edge: hardware capture from an event line, and a software clear. The bench provokes the collision by driving one event bit high in the very cycle in which a clear write naming that same bit is on the bus. It then reads the pending word after the edge and expects the bit to still be 1. A second overlap is an unprivileged clear that names a locked bit and an unlocked bit together. The bench judges it by reading back that only the unlocked bit fell.

// File: rtl/evt_intc_pkg.sv
package evt_intc_pkg;

    localparam int NUM_SRC      = 49;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 7;
    localparam int WORDS_PER_FN = (NUM_SRC + DATA_W - 1) / DATA_W;
    localparam int BANK_W       = WORDS_PER_FN * DATA_W;
    localparam int WORD_LSB     = 2;
    localparam int FN_LSB       = 3;
    localparam int FN_W         = ADDR_W - FN_LSB;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [DATA_W-1:0]  word_t;

    // Register function selected by address bits [6:3]
    typedef enum logic [FN_W-1:0] {
        FN_MASK   = 4'd0,
        FN_PEND   = 4'd1,
        FN_SET    = 4'd2,
        FN_CLR    = 4'd3,
        FN_IRQ_RT = 4'd4,
        FN_NMI_RT = 4'd5,
        FN_LOCK   = 4'd6
    } reg_fn_e;

    // One write strobe per writable function
    typedef struct packed {
        logic mask;
        logic set;
        logic clr;
        logic irq_rt;
        logic nmi_rt;
        logic lock;
    } wr_strb_t;

    // Software-visible configuration
    typedef struct packed {
        src_vec_t mask;
        src_vec_t irq_rt;
        src_vec_t nmi_rt;
        src_vec_t lock;
    } cfg_t;

    // Place a bus word into the source bank at the selected word lane
    function automatic src_vec_t lane_place(input word_t d, input logic word_hi);
        logic [BANK_W-1:0] w;
        w = '0;
        if (word_hi)
            w[BANK_W-1 -: DATA_W] = d;
        else
            w[DATA_W-1:0] = d;
        return w[NUM_SRC-1:0];
    endfunction

    // Extract one word lane of a source vector, unused bits as zero
    function automatic word_t lane_pick(input src_vec_t v, input logic word_hi);
        logic [BANK_W-1:0] w;
        w = '0;
        w[NUM_SRC-1:0] = v;
        return word_hi ? w[BANK_W-1 -: DATA_W] : w[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/evt_bus_decode.sv
module evt_bus_decode
    import evt_intc_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic              bus_priv,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_strb_t          wr_strb,
    output reg_fn_e           fn,
    output logic              word_hi,
    output logic              in_map
);

    logic            aligned;
    logic [FN_W-1:0] fn_raw;

    assign aligned = (bus_addr[WORD_LSB-1:0] == '0);
    assign fn_raw  = bus_addr[ADDR_W-1:FN_LSB];
    assign word_hi = bus_addr[WORD_LSB];
    assign in_map  = aligned && (fn_raw <= FN_LOCK);
    assign fn      = reg_fn_e'(fn_raw);

    always_comb begin
        wr_strb = '0;
        if (bus_sel && bus_write && in_map) begin
            case (fn)
                FN_MASK:   wr_strb.mask   = 1'b1;
                FN_SET:    wr_strb.set    = 1'b1;
                FN_CLR:    wr_strb.clr    = 1'b1;
                FN_IRQ_RT: wr_strb.irq_rt = 1'b1;
                FN_NMI_RT: wr_strb.nmi_rt = 1'b1;
                FN_LOCK:   wr_strb.lock   = bus_priv;
                default:   wr_strb        = '0;
            endcase
        end
    end

endmodule

// File: rtl/evt_cfg_bank.sv
module evt_cfg_bank
    import evt_intc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_strb_t wr_strb,
    input  logic     word_hi,
    input  word_t    wdata,
    output cfg_t     cfg
);

    src_vec_t wr_val;
    src_vec_t wr_keep;

    assign wr_val  = lane_place(wdata, word_hi);
    assign wr_keep = ~lane_place('1, word_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (wr_strb.mask)
                cfg.mask   <= (cfg.mask   & wr_keep) | wr_val;
            if (wr_strb.irq_rt)
                cfg.irq_rt <= (cfg.irq_rt & wr_keep) | wr_val;
            if (wr_strb.nmi_rt)
                cfg.nmi_rt <= (cfg.nmi_rt & wr_keep) | wr_val;
            if (wr_strb.lock)
                cfg.lock   <= (cfg.lock   & wr_keep) | wr_val;
        end
    end

endmodule

// File: rtl/evt_status_cell.sv
module evt_status_cell (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic set_req,
    input  logic clr_req,
    input  logic allow,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (evt)
            pend <= 1'b1;
        else if (allow && set_req)
            pend <= 1'b1;
        else if (allow && clr_req)
            pend <= 1'b0;
    end

    // R10: hardware capture outranks a software clear in the same cycle
    a_r10_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (evt && clr_req) |=> pend);

endmodule

// File: rtl/evt_out_combine.sv
module evt_out_combine
    import evt_intc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t pend,
    input  cfg_t     cfg,
    output logic     irq_out,
    output logic     nmi_out
);

    logic irq_d;
    logic nmi_d;

    assign irq_d = |(pend & cfg.mask & cfg.irq_rt);
    assign nmi_d = |(pend & cfg.nmi_rt);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out <= 1'b0;
            nmi_out <= 1'b0;
        end else begin
            irq_out <= irq_d;
            nmi_out <= nmi_d;
        end
    end

    // R5: no masked and routed pending source means no IRQ next cycle
    a_r5_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        ((pend & cfg.mask & cfg.irq_rt) == '0) |=> !irq_out);

    // R6: an NMI-routed pending source raises NMI whatever the mask says
    a_r6_nmi_unmasked: assert property (@(posedge clk) disable iff (rst)
        ((pend & cfg.nmi_rt & ~cfg.mask) != '0) |=> nmi_out);

endmodule

// File: rtl/evt_guard_intc.sv
module evt_guard_intc
    import evt_intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic               bus_sel,
    input  logic               bus_write,
    input  logic               bus_priv,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out,
    output logic               nmi_out,
    output logic [NUM_SRC-1:0] trig_out
);

    wr_strb_t wr_strb;
    reg_fn_e  fn;
    logic     word_hi;
    logic     in_map;
    cfg_t     cfg;
    src_vec_t pend;
    src_vec_t sw_bits;
    src_vec_t rd_vec;

    evt_bus_decode u_dec (
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_priv  (bus_priv),
        .bus_addr  (bus_addr),
        .wr_strb   (wr_strb),
        .fn        (fn),
        .word_hi   (word_hi),
        .in_map    (in_map)
    );

    evt_cfg_bank u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_strb (wr_strb),
        .word_hi (word_hi),
        .wdata   (bus_wdata),
        .cfg     (cfg)
    );

    assign sw_bits = lane_place(bus_wdata, word_hi);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        evt_status_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt_in[i]),
            .set_req (wr_strb.set & sw_bits[i]),
            .clr_req (wr_strb.clr & sw_bits[i]),
            .allow   (bus_priv | ~cfg.lock[i]),
            .pend    (pend[i])
        );
    end

    evt_out_combine u_out (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .cfg     (cfg),
        .irq_out (irq_out),
        .nmi_out (nmi_out)
    );

    assign trig_out = evt_in;

    always_comb begin
        case (fn)
            FN_MASK:   rd_vec = cfg.mask;
            FN_PEND:   rd_vec = pend;
            FN_IRQ_RT: rd_vec = cfg.irq_rt;
            FN_NMI_RT: rd_vec = cfg.nmi_rt;
            FN_LOCK:   rd_vec = cfg.lock;
            default:   rd_vec = '0;
        endcase
    end

    assign bus_rdata = (bus_sel && !bus_write && in_map) ? lane_pick(rd_vec, word_hi) : '0;

    // R2: every event seen at an edge is pending afterwards
    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
        (evt_in != '0) |=> ((pend & $past(evt_in)) == $past(evt_in)));

    // R9: unprivileged writes never alter the lock bits
    a_r9_lock_priv_only: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_write && !bus_priv) |=> $stable(cfg.lock));

    // R8: locked pending bits survive an unprivileged clear
    a_r8_locked_survive: assert property (@(posedge clk) disable iff (rst)
        (wr_strb.clr && !bus_priv) |=>
            ((pend & $past(pend & cfg.lock)) == $past(pend & cfg.lock)));

endmodule

// File: tb/sim_evt_guard_intc.sv
module sim_evt_guard_intc;
    import evt_intc_pkg::*;

    localparam logic [6:0] A_MASK_LO = 7'h00, A_MASK_HI = 7'h04;
    localparam logic [6:0] A_PEND_LO = 7'h08, A_PEND_HI = 7'h0C;
    localparam logic [6:0] A_SET_LO  = 7'h10, A_SET_HI  = 7'h14;
    localparam logic [6:0] A_CLR_LO  = 7'h18;
    localparam logic [6:0] A_IRQ_LO  = 7'h20;
    localparam logic [6:0] A_NMI_HI  = 7'h2C;
    localparam logic [6:0] A_LOCK_LO = 7'h30;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] evt_in = '0;
    logic               bus_sel = 1'b0;
    logic               bus_write = 1'b0;
    logic               bus_priv = 1'b0;
    logic [6:0]         bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               irq_out;
    logic               nmi_out;
    logic [NUM_SRC-1:0] trig_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    evt_guard_intc u0 (
        .clk       (clk),
        .rst       (rst),
        .evt_in    (evt_in),
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_priv  (bus_priv),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .nmi_out   (nmi_out),
        .trig_out  (trig_out)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        evt_in = '0;
        bus_sel = 1'b0;
        bus_write = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic priv);
        @(negedge clk);
        bus_sel = 1'b1;
        bus_write = 1'b1;
        bus_priv = priv;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_write = 1'b0;
        bus_priv = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1;
        bus_write = 1'b0;
        bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, {32'b0, d}, {32'b0, exp});
    endtask

    task automatic t_reset();
        do_reset();
        for (int a = 0; a < 96; a += 4)
            rd_chk("R1 register zero after reset", 7'(a), 32'h0);
        chk("R1 irq low after reset", {63'b0, irq_out}, 64'h0);
        chk("R1 nmi low after reset", {63'b0, nmi_out}, 64'h0);
    endtask

    task automatic t_event();
        logic [NUM_SRC-1:0] v;
        do_reset();
        v = '0;
        v[5] = 1'b1;
        v[48] = 1'b1;
        @(negedge clk);
        evt_in = v;
        #1 chk("R7 trig_out mirrors events", {15'b0, trig_out}, {15'b0, v});
        @(posedge clk);
        #1 evt_in = '0;
        #1 chk("R7 trig_out drops with events", {15'b0, trig_out}, 64'h0);
        rd_chk("R2 event sets low pending", A_PEND_LO, 32'h0000_0020);
        rd_chk("R2 event sets high pending", A_PEND_HI, 32'h0001_0000);
    endtask

    task automatic t_set_clear();
        do_reset();
        wr(A_SET_LO, 32'h81, 1'b0);
        rd_chk("R3 set low word", A_PEND_LO, 32'h81);
        wr(A_SET_HI, 32'h2, 1'b0);
        rd_chk("R3 set high word", A_PEND_HI, 32'h2);
        wr(A_CLR_LO, 32'h1, 1'b0);
        rd_chk("R4 clear one bit", A_PEND_LO, 32'h80);
        wr(A_CLR_LO, 32'h0, 1'b0);
        rd_chk("R4 zero clear has no effect", A_PEND_LO, 32'h80);
        wr(A_SET_LO, 32'h0, 1'b0);
        rd_chk("R3 zero set has no effect", A_PEND_LO, 32'h80);
        rd_chk("R4 high word untouched by low clear", A_PEND_HI, 32'h2);
    endtask

    task automatic t_irq();
        do_reset();
        wr(A_MASK_LO, 32'h14, 1'b0);
        wr(A_IRQ_LO, 32'h04, 1'b0);
        wr(A_SET_LO, 32'h10, 1'b0);
        @(posedge clk);
        #1 chk("R5 masked but unrouted source gives no irq", {63'b0, irq_out}, 64'h0);
        wr(A_SET_LO, 32'h04, 1'b0);
        chk("R5 irq not yet in status cycle", {63'b0, irq_out}, 64'h0);
        @(posedge clk);
        #1 chk("R5 irq one cycle after status", {63'b0, irq_out}, 64'h1);
        wr(A_MASK_LO, 32'h10, 1'b0);
        @(posedge clk);
        #1 chk("R5 mask off drops irq", {63'b0, irq_out}, 64'h0);
        chk("R6 nmi unrouted stays low", {63'b0, nmi_out}, 64'h0);
    endtask

    task automatic t_nmi();
        do_reset();
        wr(A_NMI_HI, 32'h100, 1'b0);
        wr(A_SET_HI, 32'h100, 1'b0);
        chk("R6 nmi not yet in status cycle", {63'b0, nmi_out}, 64'h0);
        @(posedge clk);
        #1 chk("R6 nmi raised with mask off", {63'b0, nmi_out}, 64'h1);
        chk("R5 irq low with mask off", {63'b0, irq_out}, 64'h0);
        wr(7'h1C, 32'h100, 1'b0);
        @(posedge clk);
        #1 chk("R6 nmi drops after clear", {63'b0, nmi_out}, 64'h0);
    endtask

    task automatic t_lock();
        do_reset();
        wr(A_LOCK_LO, 32'h8, 1'b0);
        rd_chk("R9 unprivileged lock write ignored", A_LOCK_LO, 32'h0);
        wr(A_LOCK_LO, 32'h8, 1'b1);
        rd_chk("R9 privileged lock write taken", A_LOCK_LO, 32'h8);
        wr(A_SET_LO, 32'h18, 1'b0);
        rd_chk("R8 unprivileged set skips locked bit", A_PEND_LO, 32'h10);
        wr(A_SET_LO, 32'h08, 1'b1);
        rd_chk("R8 privileged set reaches locked bit", A_PEND_LO, 32'h18);
        wr(A_CLR_LO, 32'h18, 1'b0);
        rd_chk("R8 unprivileged clear skips locked bit", A_PEND_LO, 32'h08);
        wr(A_CLR_LO, 32'h08, 1'b1);
        rd_chk("R8 privileged clear reaches locked bit", A_PEND_LO, 32'h0);
        wr(A_LOCK_LO, 32'h0, 1'b0);
        rd_chk("R9 unprivileged unlock ignored", A_LOCK_LO, 32'h8);
    endtask

    task automatic t_race();
        do_reset();
        wr(A_SET_LO, 32'hC0, 1'b0);
        @(negedge clk);
        evt_in = '0;
        evt_in[7] = 1'b1;
        bus_sel = 1'b1;
        bus_write = 1'b1;
        bus_addr = A_CLR_LO;
        bus_wdata = 32'hC0;
        @(posedge clk);
        #1;
        evt_in = '0;
        bus_sel = 1'b0;
        bus_write = 1'b0;
        rd_chk("R10 event wins over same-cycle clear", A_PEND_LO, 32'h80);
        wr(A_CLR_LO, 32'h80, 1'b0);
        rd_chk("R10 later clear drops the bit", A_PEND_LO, 32'h0);
    endtask

    task automatic t_map();
        do_reset();
        wr(A_PEND_LO, 32'hFFFF_FFFF, 1'b1);
        rd_chk("R11 pending word is read-only", A_PEND_LO, 32'h0);
        wr(A_MASK_HI, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R11 high word bits above 16 read zero", A_MASK_HI, 32'h0001_FFFF);
        wr(A_SET_LO, 32'h1, 1'b0);
        rd_chk("R11 set word reads zero", A_SET_LO, 32'h0);
        rd_chk("R11 clear word reads zero", A_CLR_LO, 32'h0);
        rd_chk("R11 unused offset reads zero", 7'h5C, 32'h0);
        wr(7'h11, 32'h2, 1'b0);
        rd_chk("R11 misaligned write ignored", A_PEND_LO, 32'h1);
        rd_chk("R11 misaligned read zero", 7'h01, 32'h0);
    endtask

    initial begin
        t_reset();
        t_event();
        t_set_clear();
        t_irq();
        t_nmi();
        t_lock();
        t_race();
        t_map();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule